// File: doc/BRIEF.md
# Banked Memory Multi-Lane DMA Controller

A byte-wide register peripheral that fronts a large paged memory. Two window registers choose which banks the host sees in its two half-size windows. Eight DMA lanes sit beside them. Each lane holds its own scratchpad address, banked-memory address, length and two bank numbers. Writing an opcode to a lane's control byte copies that lane's block in one of two directions: from the scratchpad to the banked memory, or from the banked memory to the scratchpad.

The copy runs one byte per clock over two synchronous byte-wide memory ports, each with a one-cycle read latency. A block that runs past the end of its first bank continues from offset zero of the lane's second bank. While a copy runs, the window outputs show the lane's two banks. When the copy ends they show the host's window values again. A parameter builds a read-only variant. In that variant the lane registers cannot be written, and lane offsets read as an alias of the low register page.

Top module: `bank_dma_ctrl`

## Requirements
- R1: Offset 0 holds the first window bank and offset 1 the second. Both read back at their offsets and drive `win0_bank`/`win1_bank` while idle.
- R2: Lane n (0..7) occupies offsets 32+12n to 32+12n+11. Bytes +0..+2 hold the scratchpad address, +3..+5 the banked-memory offset and +6..+8 the length, each little-endian. Byte +9 holds the first bank and byte +10 the second. Writing a byte changes only that byte, and byte +11 always reads 0.
- R3: Writing 0x01 to offset 16+n copies lane n from the scratchpad to the banked memory. Writing 0x02 copies in the opposite direction. Any other value starts nothing. Offsets 16 to 31 always read 0.
- R4: A copy of L bytes keeps `busy` high for exactly L+1 cycles. Source and destination addresses step by one byte per cycle from the lane's start addresses. Banked address = bank number × bank size + offset.
- R5: Bytes whose offset lies below the bank size use the first bank. The rest continue from offset 0 of the second bank.
- R6: While busy, `win0_bank`/`win1_bank` show the lane's first and second bank. Once busy falls, they show the values they held before the start.
- R7: A start whose length is 0 raises no `busy` and makes no memory access.
- R8: While busy, every register write is ignored, and this includes further starts.
- R9: An offset at or above 32+12×lanes reads as the register at the offset modulo 32.
- R10: With `READ_ONLY`=1, lane writes are ignored and every offset of 32 or more reads as the register at offset modulo 32.
- R11: Reset (active-low, synchronous) clears the window registers, all lane fields and `busy`.
- R12: A memory port never reads and writes in the same cycle, and no strobe is active while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| win0_bank | output | 8 | Bank shown in first window |
| win1_bank | output | 8 | Bank shown in second window |
| busy | output | 1 | Copy in progress |
| sp_addr | output | SP_AW | Scratchpad address |
| sp_re | output | 1 | Scratchpad read strobe |
| sp_we | output | 1 | Scratchpad write strobe |
| sp_wdata | output | 8 | Scratchpad write data |
| sp_rdata | input | 8 | Scratchpad read data, one cycle after `sp_re` |
| bm_addr | output | 8+BANK_AW | Banked-memory address |
| bm_re | output | 1 | Banked-memory read strobe |
| bm_we | output | 1 | Banked-memory write strobe |
| bm_wdata | output | 8 | Banked-memory write data |
| bm_rdata | input | 8 | Banked-memory read data, one cycle after `bm_re` |

## Verification
The bench builds the writable instance with `BANK_AW`=4, giving 16-byte banks, and `SP_AW`=8. A 6-byte copy that starts at offset 13 therefore crosses into the second bank. The whole 4 KiB banked space can then be modelled and checked byte by byte. A second instance with `READ_ONLY`=1 and the same sizes brings the lane-write blocking and the modulo-32 read alias of that variant within reach.

// File: rtl/bdma_pkg.sv
`timescale 1ns/1ps
// Shared constants, lane field layout and byte accessors for the banked DMA block.
// Assumes the fixed register map: 24-bit fields, 8-bit bank numbers.
package bdma_pkg;
    localparam int FIELD_W     = 24;
    localparam int BNUM_W      = 8;
    localparam int CTRL_BASE   = 16;
    localparam int LANE_BASE   = 32;
    localparam int LANE_STRIDE = 12;
    localparam int LANE_BYTES  = 11;
    localparam int ALIAS_MASK  = 31;
    localparam logic [7:0] OP_TO_BANK   = 8'h01;
    localparam logic [7:0] OP_FROM_BANK = 8'h02;

    typedef struct packed {
        logic [FIELD_W-1:0] sp_addr;
        logic [FIELD_W-1:0] bm_off;
        logic [FIELD_W-1:0] len;
        logic [BNUM_W-1:0]  bank_a;
        logic [BNUM_W-1:0]  bank_b;
    } lane_cfg_t;

    // Replace one byte of a lane record, the byte chosen by its offset inside the lane
    function automatic lane_cfg_t cfg_put(lane_cfg_t c, int b, logic [7:0] v);
        lane_cfg_t r;
        r = c;
        case (b)
            0:  r.sp_addr[7:0]   = v;
            1:  r.sp_addr[15:8]  = v;
            2:  r.sp_addr[23:16] = v;
            3:  r.bm_off[7:0]    = v;
            4:  r.bm_off[15:8]   = v;
            5:  r.bm_off[23:16]  = v;
            6:  r.len[7:0]       = v;
            7:  r.len[15:8]      = v;
            8:  r.len[23:16]     = v;
            9:  r.bank_a         = v;
            10: r.bank_b         = v;
            default: r = c;
        endcase
        return r;
    endfunction

    // Fetch one byte of a lane record, the byte chosen by its offset inside the lane
    function automatic logic [7:0] cfg_get(lane_cfg_t c, int b);
        logic [7:0] v;
        case (b)
            0:  v = c.sp_addr[7:0];
            1:  v = c.sp_addr[15:8];
            2:  v = c.sp_addr[23:16];
            3:  v = c.bm_off[7:0];
            4:  v = c.bm_off[15:8];
            5:  v = c.bm_off[23:16];
            6:  v = c.len[7:0];
            7:  v = c.len[15:8];
            8:  v = c.len[23:16];
            9:  v = c.bank_a;
            10: v = c.bank_b;
            default: v = 8'h00;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/bdma_regs.sv
`timescale 1ns/1ps
// Register file: window banks, per-lane records, read decode with aliasing,
// and start detection. Assumes writes are dropped by the caller's busy flag.
module bdma_regs
    import bdma_pkg::*;
#(
    parameter int NUM_LANES = 8,
    parameter int REG_AW    = 8,
    parameter bit READ_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    output logic [7:0]        rdata,
    output logic [7:0]        win0_q,
    output logic [7:0]        win1_q,
    output logic              start_req,
    output logic              start_to_bank,
    output lane_cfg_t         start_cfg
);
    localparam int MAP_END = LANE_BASE + LANE_STRIDE * NUM_LANES;

    lane_cfg_t cfg_q [NUM_LANES];
    logic      wr_ok;
    logic [REG_AW-1:0] eff;

    assign wr_ok = wr_en && !busy;

    // Window bank registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win0_q <= '0;
            win1_q <= '0;
        end else if (wr_ok) begin
            if (addr == REG_AW'(0)) win0_q <= wdata;
            if (addr == REG_AW'(1)) win1_q <= wdata;
        end
    end

    // Lane records: writable storage, or constant zero in the read-only build
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        if (READ_ONLY) begin : g_ro
            assign cfg_q[l] = '0;
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[l] <= '0;
                end else if (wr_ok) begin
                    for (int b = 0; b < LANE_BYTES; b++) begin
                        if (addr == REG_AW'(LANE_BASE + l * LANE_STRIDE + b))
                            cfg_q[l] <= cfg_put(cfg_q[l], b, wdata);
                    end
                end
            end
        end
    end

    // Read decode with modulo-32 aliasing outside the live map
    always_comb begin
        eff = addr;
        if (int'(addr) >= MAP_END || (READ_ONLY && int'(addr) >= LANE_BASE))
            eff = addr & REG_AW'(ALIAS_MASK);
        rdata = 8'h00;
        if (eff == REG_AW'(0)) rdata = win0_q;
        if (eff == REG_AW'(1)) rdata = win1_q;
        for (int l = 0; l < NUM_LANES; l++) begin
            for (int b = 0; b < LANE_BYTES; b++) begin
                if (eff == REG_AW'(LANE_BASE + l * LANE_STRIDE + b))
                    rdata = cfg_get(cfg_q[l], b);
            end
        end
    end

    // Start detection on a valid opcode written to a lane control offset
    always_comb begin
        start_req     = 1'b0;
        start_to_bank = (wdata == OP_TO_BANK);
        start_cfg     = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (addr == REG_AW'(CTRL_BASE + l)) begin
                start_cfg = cfg_q[l];
                start_req = wr_ok && (wdata == OP_TO_BANK || wdata == OP_FROM_BANK);
            end
        end
    end
endmodule

// File: rtl/bdma_seq.sv
`timescale 1ns/1ps
// Transfer sequencer: streams one byte per cycle between the two memories.
// Assumes both memories return read data one cycle after the read strobe.
// Reads and writes overlap, so a copy of L bytes takes L+1 cycles.
module bdma_seq
    import bdma_pkg::*;
#(
    parameter int BANK_AW = 19,
    parameter int SP_AW   = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_req,
    input  logic                      start_to_bank,
    input  lane_cfg_t                 start_cfg,
    output logic                      busy,
    output logic [BNUM_W-1:0]         bank_a_o,
    output logic [BNUM_W-1:0]         bank_b_o,
    output logic [SP_AW-1:0]          sp_addr,
    output logic                      sp_re,
    output logic                      sp_we,
    output logic [7:0]                sp_wdata,
    input  logic [7:0]                sp_rdata,
    output logic [BNUM_W+BANK_AW-1:0] bm_addr,
    output logic                      bm_re,
    output logic                      bm_we,
    output logic [7:0]                bm_wdata,
    input  logic [7:0]                bm_rdata
);
    localparam int BM_AW = BNUM_W + BANK_AW;

    logic               run_q, to_bank_q, pend_q, second_q;
    logic [FIELD_W-1:0] remain_q;
    logic [SP_AW-1:0]   sp_cur_q, sp_prev_q;
    logic [BANK_AW-1:0] off_cur_q;
    logic [BNUM_W-1:0]  bank_a_q, bank_b_q;
    logic [BM_AW-1:0]   bm_prev_q, bm_cur;
    logic               rd_go, go;
    logic               unused_bits;

    assign unused_bits = ^start_cfg.sp_addr[FIELD_W-1:SP_AW];
    assign go     = start_req && !run_q && (start_cfg.len != '0);
    assign rd_go  = run_q && (remain_q != '0);
    assign bm_cur = {second_q ? bank_b_q : bank_a_q, off_cur_q};

    // Memory strobes and addresses: writes use the address of the previous read
    always_comb begin
        sp_re    = rd_go && to_bank_q;
        bm_re    = rd_go && !to_bank_q;
        sp_we    = pend_q && !to_bank_q;
        bm_we    = pend_q && to_bank_q;
        sp_addr  = sp_we ? sp_prev_q : sp_cur_q;
        bm_addr  = bm_we ? bm_prev_q : bm_cur;
        sp_wdata = bm_rdata;
        bm_wdata = sp_rdata;
    end

    // Copy state: load on start, then step read addresses and the bank switch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            to_bank_q <= 1'b0;
            pend_q    <= 1'b0;
            second_q  <= 1'b0;
            remain_q  <= '0;
            sp_cur_q  <= '0;
            sp_prev_q <= '0;
            off_cur_q <= '0;
            bank_a_q  <= '0;
            bank_b_q  <= '0;
            bm_prev_q <= '0;
        end else if (go) begin
            run_q     <= 1'b1;
            to_bank_q <= start_to_bank;
            pend_q    <= 1'b0;
            remain_q  <= start_cfg.len;
            sp_cur_q  <= start_cfg.sp_addr[SP_AW-1:0];
            off_cur_q <= start_cfg.bm_off[BANK_AW-1:0];
            second_q  <= |start_cfg.bm_off[FIELD_W-1:BANK_AW];
            bank_a_q  <= start_cfg.bank_a;
            bank_b_q  <= start_cfg.bank_b;
        end else if (run_q) begin
            pend_q <= rd_go;
            if (rd_go) begin
                sp_prev_q <= sp_cur_q;
                bm_prev_q <= bm_cur;
                sp_cur_q  <= sp_cur_q + 1'b1;
                remain_q  <= remain_q - 1'b1;
                if (off_cur_q == '1) begin
                    off_cur_q <= '0;
                    second_q  <= 1'b1;
                end else begin
                    off_cur_q <= off_cur_q + 1'b1;
                end
            end else begin
                run_q <= 1'b0;
            end
        end
    end

    assign busy     = run_q;
    assign bank_a_o = bank_a_q;
    assign bank_b_o = bank_b_q;
endmodule

// File: rtl/bank_dma_ctrl.sv
`timescale 1ns/1ps
// Top level: register file plus transfer sequencer. The window outputs show
// the active lane's banks while busy and the host's values otherwise.
// Assumes BANK_AW < 24 and NUM_LANES <= 8.
module bank_dma_ctrl
    import bdma_pkg::*;
#(
    parameter int NUM_LANES = 8,
    parameter int BANK_AW   = 19,
    parameter int SP_AW     = 24,
    parameter int REG_AW    = 8,
    parameter bit READ_ONLY = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic [7:0]           win0_bank,
    output logic [7:0]           win1_bank,
    output logic                 busy,
    output logic [SP_AW-1:0]     sp_addr,
    output logic                 sp_re,
    output logic                 sp_we,
    output logic [7:0]           sp_wdata,
    input  logic [7:0]           sp_rdata,
    output logic [8+BANK_AW-1:0] bm_addr,
    output logic                 bm_re,
    output logic                 bm_we,
    output logic [7:0]           bm_wdata,
    input  logic [7:0]           bm_rdata
);
    logic [7:0]        win0_q, win1_q, bank_a, bank_b;
    logic              start_req, start_to_bank;
    lane_cfg_t         start_cfg;

    bdma_regs #(
        .NUM_LANES(NUM_LANES), .REG_AW(REG_AW), .READ_ONLY(READ_ONLY)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .busy(busy), .rdata(reg_rdata),
        .win0_q(win0_q), .win1_q(win1_q), .start_req(start_req),
        .start_to_bank(start_to_bank), .start_cfg(start_cfg)
    );

    bdma_seq #(
        .BANK_AW(BANK_AW), .SP_AW(SP_AW)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .start_to_bank(start_to_bank), .start_cfg(start_cfg), .busy(busy),
        .bank_a_o(bank_a), .bank_b_o(bank_b),
        .sp_addr(sp_addr), .sp_re(sp_re), .sp_we(sp_we),
        .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
        .bm_addr(bm_addr), .bm_re(bm_re), .bm_we(bm_we),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata)
    );

    // Window outputs: lane banks during a copy, host registers otherwise
    assign win0_bank = busy ? bank_a : win0_q;
    assign win1_bank = busy ? bank_b : win1_q;
endmodule

// File: rtl/bank_dma_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for bank_dma_ctrl, attached by bind. Watches ports only.
module bank_dma_ctrl_chk #(
    parameter int REG_AW = 8,
    parameter int SP_AW  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic [7:0]        win0_bank,
    input logic [7:0]        win1_bank,
    input logic              busy,
    input logic [SP_AW-1:0]  sp_addr,
    input logic              sp_re,
    input logic              sp_we,
    input logic              bm_re,
    input logic              bm_we
);
    logic [7:0] held0, held1;

    // Remember the idle window values so the restore can be compared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held0 <= '0;
            held1 <= '0;
        end else if (!busy) begin
            held0 <= win0_bank;
            held1 <= win1_bank;
        end
    end

    // R6
    win_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (win0_bank == held0 && win1_bank == held1));

    // R3
    ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) >= 16 && int'(reg_addr) < 32) |-> reg_rdata == 8'h00);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(sp_re || sp_we || bm_re || bm_we));

    // R12
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sp_re, sp_we}) && $onehot0({bm_re, bm_we}));

    // R4
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && $past(sp_we)) |-> sp_addr == SP_AW'($past(sp_addr) + 1'b1));

    // R4
    sp_rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_re && $past(sp_re)) |-> sp_addr == SP_AW'($past(sp_addr) + 1'b1));
endmodule

bind bank_dma_ctrl bank_dma_ctrl_chk #(.REG_AW(REG_AW), .SP_AW(SP_AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .win0_bank(win0_bank), .win1_bank(win1_bank), .busy(busy),
    .sp_addr(sp_addr), .sp_re(sp_re), .sp_we(sp_we),
    .bm_re(bm_re), .bm_we(bm_we)
);

// File: tb/bank_dma_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, memories modelled with one-cycle reads.
module bank_dma_ctrl_tb_top;
    localparam int BAW = 4;
    localparam int SAW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic [7:0] win0_bank, win1_bank;
    logic       busy;
    logic [SAW-1:0] sp_addr;
    logic       sp_re, sp_we;
    logic [7:0] sp_wdata, sp_rdata = '0;
    logic [8+BAW-1:0] bm_addr;
    logic       bm_re, bm_we;
    logic [7:0] bm_wdata, bm_rdata = '0;

    logic       ro_we = 1'b0;
    logic [7:0] ro_addr = '0, ro_wdata = '0, ro_rdata;
    logic [7:0] ro_w0, ro_w1, ro_wd0, ro_wd1;
    logic       ro_busy, ro_s0, ro_s1, ro_s2, ro_s3;
    logic [SAW-1:0] ro_sa;
    logic [8+BAW-1:0] ro_ba;

    logic [7:0] sp_mem [256];
    logic [7:0] bm_mem [4096];

    int n_total = 0;
    int n_fail  = 0;
    int busy_cnt = 0;

    bank_dma_ctrl #(.BANK_AW(BAW), .SP_AW(SAW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win0_bank(win0_bank),
        .win1_bank(win1_bank), .busy(busy), .sp_addr(sp_addr), .sp_re(sp_re),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
        .bm_addr(bm_addr), .bm_re(bm_re), .bm_we(bm_we),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata)
    );

    bank_dma_ctrl #(.BANK_AW(BAW), .SP_AW(SAW), .READ_ONLY(1'b1)) dut_ro_i (
        .clk(clk), .rst_n(rst_n), .reg_we(ro_we), .reg_addr(ro_addr),
        .reg_wdata(ro_wdata), .reg_rdata(ro_rdata), .win0_bank(ro_w0),
        .win1_bank(ro_w1), .busy(ro_busy), .sp_addr(ro_sa), .sp_re(ro_s0),
        .sp_we(ro_s1), .sp_wdata(ro_wd0), .sp_rdata(8'h00),
        .bm_addr(ro_ba), .bm_re(ro_s2), .bm_we(ro_s3),
        .bm_wdata(ro_wd1), .bm_rdata(8'h00)
    );

    // Memory models with one-cycle read latency
    always @(posedge clk) begin
        if (sp_re) sp_rdata <= sp_mem[sp_addr];
        if (sp_we) sp_mem[sp_addr] <= sp_wdata;
        if (bm_re) bm_rdata <= bm_mem[bm_addr];
        if (bm_we) bm_mem[bm_addr] <= bm_wdata;
    end

    // Busy-cycle counter sampled away from the active edge
    always @(negedge clk) if (busy) busy_cnt++;

    task automatic check(string req, int act, int exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_lane(int l, int spa, int off, int len, int ba, int bb);
        int base = 32 + 12 * l;
        for (int b = 0; b < 3; b++) begin
            wr(8'(base + b), 8'(spa >> (8 * b)));
            wr(8'(base + 3 + b), 8'(off >> (8 * b)));
            wr(8'(base + 6 + b), 8'(len >> (8 * b)));
        end
        wr(8'(base + 9), 8'(ba));
        wr(8'(base + 10), 8'(bb));
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R11 busy", busy, 0);
        check("R11 win0", win0_bank, 0);
        check("R11 win1", win1_bank, 0);
        rd(8'd1, d);  check("R11 reg1", d, 0);
        rd(8'd38, d); check("R11 lane0 len", d, 0);
        rd(8'd77, d); check("R11 lane3 bank", d, 0);
    endtask

    task automatic t_windows();
        logic [7:0] d;
        wr(8'd0, 8'h11);
        wr(8'd1, 8'h22);
        rd(8'd0, d); check("R1 reg0", d, 8'h11);
        rd(8'd1, d); check("R1 reg1", d, 8'h22);
        check("R1 win0 out", win0_bank, 8'h11);
        check("R1 win1 out", win1_bank, 8'h22);
    endtask

    task automatic t_fields();
        logic [7:0] d;
        wr(8'd44, 8'h12);
        wr(8'd45, 8'h34);
        wr(8'd44, 8'h56);
        wr(8'd55, 8'hFF);
        rd(8'd44, d); check("R2 byte0 replaced", d, 8'h56);
        rd(8'd45, d); check("R2 byte1 kept", d, 8'h34);
        rd(8'd46, d); check("R2 byte2 untouched", d, 8'h00);
        rd(8'd55, d); check("R2 byte11 reads 0", d, 8'h00);
        rd(8'd16, d); check("R3 ctrl reads 0", d, 8'h00);
        rd(8'd28, d); check("R3 reserved reads 0", d, 8'h00);
    endtask

    task automatic t_to_bank();
        set_lane(0, 8'h10, 3, 5, 2, 7);
        busy_cnt = 0;
        wr(8'd16, 8'h01);
        check("R6 win0 during copy", win0_bank, 2);
        check("R6 win1 during copy", win1_bank, 7);
        wait_idle();
        check("R4 busy cycles", busy_cnt, 6);
        for (int i = 0; i < 5; i++)
            check("R4 bank data", bm_mem[2 * 16 + 3 + i], 8'hA0 + i);
        check("R4 no write past end", bm_mem[2 * 16 + 8], (2 * 16 + 8) ^ 8'h5A);
        check("R6 win0 restored", win0_bank, 8'h11);
        check("R6 win1 restored", win1_bank, 8'h22);
    endtask

    task automatic t_cross();
        set_lane(3, 8'h40, 13, 6, 5, 9);
        busy_cnt = 0;
        wr(8'd19, 8'h02);
        wait_idle();
        check("R5 busy cycles", busy_cnt, 7);
        for (int i = 0; i < 6; i++) begin
            int src = (i < 3) ? (5 * 16 + 13 + i) : (9 * 16 + i - 3);
            check("R5 crossing data", sp_mem[8'h40 + i], src ^ 8'h5A);
        end
        check("R5 no extra byte", sp_mem[8'h46], 8'h00);
    endtask

    task automatic t_zero_and_badop();
        set_lane(1, 8'h00, 0, 0, 1, 1);
        busy_cnt = 0;
        wr(8'd17, 8'h01);
        repeat (3) @(negedge clk);
        check("R7 no busy", busy_cnt, 0);
        check("R7 memory untouched", bm_mem[16], 16 ^ 8'h5A);
        sp_mem[8'h10] = 8'hEE;
        wr(8'd16, 8'h03);
        repeat (3) @(negedge clk);
        check("R3 bad opcode no busy", busy_cnt, 0);
        check("R3 bad opcode no copy", bm_mem[35], 8'hA0);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d;
        busy_cnt = 0;
        wr(8'd16, 8'h01);
        wr(8'd0, 8'h77);
        wr(8'd32, 8'h99);
        wait_idle();
        check("R8 single copy length", busy_cnt, 6);
        rd(8'd0, d);  check("R8 window write ignored", d, 8'h11);
        rd(8'd32, d); check("R8 lane write ignored", d, 8'h10);
        check("R8 copy still done", bm_mem[35], 8'hEE);
    endtask

    task automatic t_alias();
        logic [7:0] d;
        rd(8'd129, d); check("R9 alias to reg1", d, 8'h22);
        rd(8'd160, d); check("R9 alias to reg0", d, 8'h11);
        rd(8'd136, d); check("R9 alias to empty", d, 8'h00);
    endtask

    task automatic t_read_only();
        @(negedge clk);
        ro_we = 1'b1; ro_addr = 8'd1; ro_wdata = 8'h3C;
        @(negedge clk);
        ro_addr = 8'd41; ro_wdata = 8'h99;
        @(negedge clk);
        ro_we = 1'b0; ro_addr = 8'd33;
        #1 check("R10 lane offset aliases reg1", ro_rdata, 8'h3C);
        @(negedge clk);
        ro_addr = 8'd41;
        #1 check("R10 lane write ignored", ro_rdata, 8'h00);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) sp_mem[i] = 8'h00;
        for (int i = 0; i < 5; i++) sp_mem[8'h10 + i] = 8'hA0 + i;
        for (int i = 0; i < 4096; i++) bm_mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_windows();
        t_fields();
        t_to_bank();
        t_cross();
        t_zero_and_badop();
        t_busy_ignore();
        t_alias();
        t_read_only();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule